// File: doc/BRIEF.md
# Command-Frame SPI Target with Channel Configuration Registers

This block is a serial target for a four-wire SPI link running in mode 1 (clock idles low; the controller launches data on the rising edge and the target samples on the falling edge). Every exchange is one 16-bit frame. The top two bits select one of four operations. The next three bits are ignored. A 3-bit address and an 8-bit data byte follow. The operations are: read diagnosis only, read a register in the next frame, restore every register to its default, and write a register. Seven addresses are decoded. Six of them hold per-channel configuration bytes that are presented continuously at the outputs. The seventh, at address 6, reads back the live output-state byte supplied at an input.

All logic runs on a system clock. The serial pins pass through a synchronizer and an edge detector. When chip select falls, a 16-bit word is loaded into the transmit shifter. This is normally the external diagnosis word. If the previous frame was an accepted read, it is the read response instead. A frame takes effect only at the rising edge of chip select, and only if two conditions hold. The number of serial clocks must be a nonzero multiple of 8. The command and address must also form a legal combination. An accepted frame emits a one-cycle pulse that tells the surrounding logic to clear its diagnosis store. A restore-defaults frame also emits a second pulse.

Top module: `cmd_spi_target`

## Requirements
- R1: Bits on `sdi_i` are taken on falling `sclk_i` edges, most significant first. `sdo_o` changes after rising `sclk_i` edges, most significant first. The first bit is already present after chip select falls, and bits past the sixteenth read 0.
- R2: While `csn_i` is high, `sdo_oe_o` is 0, and toggling `sclk_i` or `sdi_i` changes no register, emits no pulse and leaves no read pending.
- R3: When `csn_i` falls and no read is pending, the frame returns the value of `diag_i` sampled at that moment.
- R4: Frame bit fields are: operation in bits 15:14, ignored bits 13:11, address in bits 10:8, data in bits 7:0. Operation 11 writes the data byte to address 1 (`route_o`), 2 (`combine_o`), 3 (`ovl_latch_o`), 4 (`temp_latch_o`), 5 (`slow_slew_o`) or 7 (`switch_o`).
- R5: After an accepted operation 01, the next frame returns `{5'b01000, address, data}`. Address 6 returns `out_state_i` as sampled when that next frame starts. The read has no other effect.
- R6: An accepted operation 10 sets `route_o` to 08h and all other configuration outputs to 00h. It pulses `regs_rst_o` for one cycle.
- R7: Operation 00 changes no register and creates no pending read. It only produces the clear pulse.
- R8: A frame whose serial-clock count is zero or not a multiple of 8 changes nothing and emits no pulse. A frame longer than 16 clocks (24, for example) uses its last 16 bits. A shorter one uses its bits with zeros above them.
- R9: Operations 01 and 11 with address 0, and operation 11 with address 6, are rejected: no register change, no pending read, no pulse.
- R10: Each accepted frame produces exactly one single-cycle `diag_clr_o` pulse a few cycles after `csn_i` rises, while `sdo_oe_o` is 0.
- R11: While `rst_n` is low, all configuration outputs hold their defaults (08h for `route_o`, 00h otherwise), `sdo_oe_o` is 0, no pulses occur, and any pending read is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csn_i | input | 1 | Chip select, active low |
| sclk_i | input | 1 | Serial clock, idles low |
| sdi_i | input | 1 | Serial data from the controller |
| sdo_o | output | 1 | Serial data to the controller |
| sdo_oe_o | output | 1 | Drive enable for the pad of `sdo_o` |
| diag_i | input | 16 | Diagnosis word shifted out in ordinary frames |
| out_state_i | input | 8 | Live output states, readable at address 6 |
| route_o | output | 8 | Per-channel routing of the shared parallel input |
| combine_o | output | 8 | Per-channel combine mode (1 = AND, 0 = OR) |
| ovl_latch_o | output | 8 | Per-channel overload shutdown latch enable |
| temp_latch_o | output | 8 | Per-channel overtemperature latch enable |
| slow_slew_o | output | 8 | Per-channel slow-edge select |
| switch_o | output | 8 | Per-channel serial on/off command |
| diag_clr_o | output | 1 | One-cycle pulse after an accepted frame |
| regs_rst_o | output | 1 | One-cycle pulse after an accepted restore-defaults frame |

## Verification
The assertions assume the controller keeps `csn_i` stable for far longer than the synchronizer depth. They also assume `sclk_i` is low whenever chip select changes and that pin changes are slow relative to the system clock. The "released" check, for example, counts only runs of `csn_i` high that are longer than the synchronizer plus edge detector. The bench holds every half serial period and every gap between frames for eight or more system clocks, and moves `sdi_i` only together with a rising `sclk_i`. No glitch or edge shorter than the synchronizer ever reaches the block.

// File: rtl/cmd_spi_pkg.sv
package cmd_spi_pkg;

   // Operation codes carried in the top two bits of a frame.
   typedef enum logic [1:0] {
      OP_DIAG  = 2'b00,
      OP_READ  = 2'b01,
      OP_CLEAR = 2'b10,
      OP_WRITE = 2'b11
   } op_e;

   // Register addresses; the bench and the register file depend on these values.
   localparam int ADDR_ROUTE   = 1;
   localparam int ADDR_COMBINE = 2;
   localparam int ADDR_OVL     = 3;
   localparam int ADDR_TEMP    = 4;
   localparam int ADDR_SLEW    = 5;
   localparam int ADDR_STATE   = 6;
   localparam int ADDR_SWITCH  = 7;

   // Legal operation/address pairings; anything else is a rejected frame.
   function automatic logic op_accepted(input op_e op, input int unsigned addr);
      case (op)
         OP_DIAG, OP_CLEAR: return 1'b1;
         OP_READ:           return addr != 0;
         default:           return (addr != 0) && (addr != ADDR_STATE);
      endcase
   endfunction

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic csn_i,
   input  logic sclk_i,
   input  logic sdi_i,
   output logic sdi_s,
   output logic cs_fall,
   output logic cs_rise,
   output logic sclk_rise,
   output logic sclk_fall
);

   localparam int PIN_N = 3;                         // {csn, sclk, sdi}
   localparam logic [PIN_N-1:0] PIN_IDLE = 3'b100;   // deselected, clock low

   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("spi_pin_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0][PIN_N-1:0] pipe;
   logic [1:0]                   prev;   // {csn, sclk} one cycle older than the last stage
   logic                         csn_s, sclk_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pipe <= {STAGES{PIN_IDLE}};
         prev <= 2'b10;
      end else begin
         pipe <= {pipe[STAGES-2:0], {csn_i, sclk_i, sdi_i}};
         prev <= {csn_s, sclk_s};
      end
   end

   assign csn_s     = pipe[STAGES-1][2];
   assign sclk_s    = pipe[STAGES-1][1];
   assign sdi_s     = pipe[STAGES-1][0];
   assign cs_fall   =  prev[1] & ~csn_s;
   assign cs_rise   = ~prev[1] &  csn_s;
   assign sclk_rise = ~prev[0] &  sclk_s;
   assign sclk_fall =  prev[0] & ~sclk_s;

endmodule

// File: rtl/spi_frame_shifter.sv
module spi_frame_shifter #(
   parameter int FRAME_W = 16,
   parameter int BYTE_W  = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sdi_s,
   input  logic               cs_fall,
   input  logic               cs_rise,
   input  logic               sclk_rise,
   input  logic               sclk_fall,
   input  logic [FRAME_W-1:0] load_word,
   output logic [FRAME_W-1:0] rx_word,
   output logic               done,
   output logic               len_ok,
   output logic               sdo,
   output logic               active
);

   localparam int CNT_W = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;

   generate
      if ((BYTE_W & (BYTE_W - 1)) != 0) begin : g_bad_byte
         $error("spi_frame_shifter: BYTE_W must be a power of two");
      end
      if (FRAME_W % BYTE_W != 0) begin : g_bad_frame
         $error("spi_frame_shifter: FRAME_W must be a whole number of bytes");
      end
   endgenerate

   logic [FRAME_W-1:0] tx;
   logic [CNT_W-1:0]   beat;   // clock count modulo BYTE_W
   logic               seen;   // at least one falling edge in this frame

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active  <= 1'b0;
         tx      <= '0;
         rx_word <= '0;
         beat    <= '0;
         seen    <= 1'b0;
         sdo     <= 1'b0;
         done    <= 1'b0;
         len_ok  <= 1'b0;
      end else begin
         done <= 1'b0;
         if (cs_fall) begin
            active  <= 1'b1;
            tx      <= load_word;
            sdo     <= load_word[FRAME_W-1];
            rx_word <= '0;
            beat    <= '0;
            seen    <= 1'b0;
         end else if (active) begin
            if (cs_rise) begin
               active <= 1'b0;
               done   <= 1'b1;
               len_ok <= seen && (beat == '0);
            end else begin
               if (sclk_rise) begin
                  sdo <= tx[FRAME_W-1];
                  tx  <= {tx[FRAME_W-2:0], 1'b0};
               end
               if (sclk_fall) begin
                  rx_word <= {rx_word[FRAME_W-2:0], sdi_s};
                  beat    <= beat + 1'b1;
                  seen    <= 1'b1;
               end
            end
         end
      end
   end

endmodule

// File: rtl/cfg_regfile.sv
module cfg_regfile
   import cmd_spi_pkg::*;
#(
   parameter int                DATA_W        = 8,
   parameter int                ADDR_W        = 3,
   parameter logic [DATA_W-1:0] ROUTE_DEFAULT = 8'h08
) (
   input  logic                                   clk,
   input  logic                                   rst_n,
   input  logic                                   wr_en,
   input  logic [ADDR_W-1:0]                      wr_addr,
   input  logic [DATA_W-1:0]                      wr_data,
   input  logic                                   clr_all,
   input  logic [DATA_W-1:0]                      out_state_i,
   input  logic [ADDR_W-1:0]                      rd_addr,
   output logic [DATA_W-1:0]                      rd_data,
   output logic [(1<<ADDR_W)-1:0][DATA_W-1:0]     bank_o
);

   localparam int NUM_ADDR = 1 << ADDR_W;

   generate
      for (genvar a = 0; a < NUM_ADDR; a++) begin : g_slot
         if (a == 0) begin : g_none
            assign bank_o[a] = '0;
         end else if (a == ADDR_STATE) begin : g_live
            assign bank_o[a] = out_state_i;
         end else begin : g_cfg
            localparam logic [DATA_W-1:0] RST_VAL = (a == ADDR_ROUTE) ? ROUTE_DEFAULT : '0;
            logic [DATA_W-1:0] q;
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)                                     q <= RST_VAL;
               else if (clr_all)                               q <= RST_VAL;
               else if (wr_en && (wr_addr == ADDR_W'(a)))      q <= wr_data;
            end
            assign bank_o[a] = q;
         end
      end
   endgenerate

   assign rd_data = bank_o[rd_addr];

endmodule

// File: rtl/cmd_spi_target.sv
module cmd_spi_target
   import cmd_spi_pkg::*;
#(
   parameter int                DATA_W        = 8,
   parameter int                ADDR_W        = 3,
   parameter int                CMD_W         = 2,
   parameter int                FRAME_W       = 16,
   parameter int                BYTE_W        = 8,
   parameter int                SYNC_STAGES   = 2,
   parameter logic [DATA_W-1:0] ROUTE_DEFAULT = 8'h08
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               csn_i,
   input  logic               sclk_i,
   input  logic               sdi_i,
   output logic               sdo_o,
   output logic               sdo_oe_o,
   input  logic [FRAME_W-1:0] diag_i,
   input  logic [DATA_W-1:0]  out_state_i,
   output logic [DATA_W-1:0]  route_o,
   output logic [DATA_W-1:0]  combine_o,
   output logic [DATA_W-1:0]  ovl_latch_o,
   output logic [DATA_W-1:0]  temp_latch_o,
   output logic [DATA_W-1:0]  slow_slew_o,
   output logic [DATA_W-1:0]  switch_o,
   output logic               diag_clr_o,
   output logic               regs_rst_o
);

   localparam int HDR_W  = FRAME_W - ADDR_W - DATA_W;      // read-response header width
   localparam int SKIP_W = FRAME_W - CMD_W - ADDR_W - DATA_W;
   localparam logic [HDR_W-1:0] RD_HDR = HDR_W'(1) << (HDR_W - 2);   // 0,1 then zeros

   generate
      if (CMD_W != 2) begin : g_bad_cmd
         $error("cmd_spi_target: CMD_W must be 2");
      end
      if (ADDR_W != 3) begin : g_bad_addr
         $error("cmd_spi_target: the register map needs ADDR_W of 3");
      end
      if (SKIP_W < 0 || HDR_W < 2) begin : g_bad_frame
         $error("cmd_spi_target: FRAME_W too small for command, address and data");
      end
   endgenerate

   logic               sdi_s, cs_fall, cs_rise, sclk_rise, sclk_fall;
   logic [FRAME_W-1:0] rx_word, load_word;
   logic               done, len_ok;
   op_e                op;
   logic [ADDR_W-1:0]  f_addr;
   logic [DATA_W-1:0]  f_data;
   logic               commit, wr_en, clr_all;
   logic               rd_pend;
   logic [ADDR_W-1:0]  rd_addr;
   logic [DATA_W-1:0]  rd_data;
   logic [(1<<ADDR_W)-1:0][DATA_W-1:0] bank;

   spi_pin_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .csn_i     (csn_i),
      .sclk_i    (sclk_i),
      .sdi_i     (sdi_i),
      .sdi_s     (sdi_s),
      .cs_fall   (cs_fall),
      .cs_rise   (cs_rise),
      .sclk_rise (sclk_rise),
      .sclk_fall (sclk_fall)
   );

   spi_frame_shifter #(.FRAME_W(FRAME_W), .BYTE_W(BYTE_W)) i_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .sdi_s     (sdi_s),
      .cs_fall   (cs_fall),
      .cs_rise   (cs_rise),
      .sclk_rise (sclk_rise),
      .sclk_fall (sclk_fall),
      .load_word (load_word),
      .rx_word   (rx_word),
      .done      (done),
      .len_ok    (len_ok),
      .sdo       (sdo_o),
      .active    (sdo_oe_o)
   );

   // Frame field split.
   assign op     = op_e'(rx_word[FRAME_W-1 -: CMD_W]);
   assign f_addr = rx_word[ADDR_W+DATA_W-1 -: ADDR_W];
   assign f_data = rx_word[DATA_W-1:0];

   // A frame commits only with a whole number of bytes and a legal command.
   assign commit  = done && len_ok && op_accepted(op, int'(f_addr));
   assign wr_en   = commit && (op == OP_WRITE);
   assign clr_all = commit && (op == OP_CLEAR);

   cfg_regfile #(
      .DATA_W        (DATA_W),
      .ADDR_W        (ADDR_W),
      .ROUTE_DEFAULT (ROUTE_DEFAULT)
   ) i_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en       (wr_en),
      .wr_addr     (f_addr),
      .wr_data     (f_data),
      .clr_all     (clr_all),
      .out_state_i (out_state_i),
      .rd_addr     (rd_addr),
      .rd_data     (rd_data),
      .bank_o      (bank)
   );

   // Pending read: armed by an accepted read, consumed by the next chip-select fall.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_pend <= 1'b0;
         rd_addr <= '0;
      end else if (cs_fall) begin
         rd_pend <= 1'b0;
      end else if (commit && (op == OP_READ)) begin
         rd_pend <= 1'b1;
         rd_addr <= f_addr;
      end
   end

   assign load_word = rd_pend ? {RD_HDR, rd_addr, rd_data} : diag_i;

   // Strobes land in the same cycle as the register update they accompany.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         diag_clr_o <= 1'b0;
         regs_rst_o <= 1'b0;
      end else begin
         diag_clr_o <= commit;
         regs_rst_o <= clr_all;
      end
   end

   assign route_o      = bank[ADDR_ROUTE];
   assign combine_o    = bank[ADDR_COMBINE];
   assign ovl_latch_o  = bank[ADDR_OVL];
   assign temp_latch_o = bank[ADDR_TEMP];
   assign slow_slew_o  = bank[ADDR_SLEW];
   assign switch_o     = bank[ADDR_SWITCH];

endmodule

// File: rtl/cmd_spi_checker.sv
module cmd_spi_checker #(
   parameter int                DATA_W        = 8,
   parameter int                SYNC_STAGES   = 2,
   parameter logic [DATA_W-1:0] ROUTE_DEFAULT = 8'h08
) (
   input logic              clk,
   input logic              rst_n,
   input logic              csn_i,
   input logic              sdo_oe_o,
   input logic              diag_clr_o,
   input logic              regs_rst_o,
   input logic [DATA_W-1:0] route_o,
   input logic [DATA_W-1:0] combine_o,
   input logic [DATA_W-1:0] ovl_latch_o,
   input logic [DATA_W-1:0] temp_latch_o,
   input logic [DATA_W-1:0] slow_slew_o,
   input logic [DATA_W-1:0] switch_o
);

   localparam int HI_LIM = SYNC_STAGES + 3;
   localparam int HI_W   = $clog2(HI_LIM + 2);

   logic [HI_W-1:0]       hi_run;
   logic [6*DATA_W-1:0]   cfg;

   assign cfg = {route_o, combine_o, ovl_latch_o, temp_latch_o, slow_slew_o, switch_o};

   // Length of the current run of chip select held high, saturating.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        hi_run <= '0;
      else if (!csn_i)                   hi_run <= '0;
      else if (hi_run != HI_W'(HI_LIM))  hi_run <= hi_run + 1'b1;
   end

   // R2: a long deselect releases the data-out pad.
   a_r2_sdo_released: assert property (@(posedge clk) disable iff (!rst_n)
      (hi_run == HI_W'(HI_LIM)) |-> !sdo_oe_o);

   // R6: restore-defaults leaves every register at its default value.
   a_r6_defaults_on_clear: assert property (@(posedge clk) disable iff (!rst_n)
      regs_rst_o |-> (route_o == ROUTE_DEFAULT && combine_o == '0 && ovl_latch_o == '0 &&
                      temp_latch_o == '0 && slow_slew_o == '0 && switch_o == '0));

   // R6: restore-defaults is an accepted frame and so also clears diagnosis.
   a_r6_clear_is_commit: assert property (@(posedge clk) disable iff (!rst_n)
      regs_rst_o |-> diag_clr_o);

   // R8, R9: configuration changes only together with an accepted frame.
   a_r9_change_needs_commit: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg != $past(cfg)) |-> diag_clr_o);

   // R10: the clear strobe lasts one cycle.
   a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      diag_clr_o |=> !diag_clr_o);

   // R10: commits happen only after the frame has ended.
   a_r10_commit_idle: assert property (@(posedge clk) disable iff (!rst_n)
      diag_clr_o |-> !sdo_oe_o);

endmodule

bind cmd_spi_target cmd_spi_checker #(
   .DATA_W        (DATA_W),
   .SYNC_STAGES   (SYNC_STAGES),
   .ROUTE_DEFAULT (ROUTE_DEFAULT)
) i_cmd_spi_checker (
   .clk          (clk),
   .rst_n        (rst_n),
   .csn_i        (csn_i),
   .sdo_oe_o     (sdo_oe_o),
   .diag_clr_o   (diag_clr_o),
   .regs_rst_o   (regs_rst_o),
   .route_o      (route_o),
   .combine_o    (combine_o),
   .ovl_latch_o  (ovl_latch_o),
   .temp_latch_o (temp_latch_o),
   .slow_slew_o  (slow_slew_o),
   .switch_o     (switch_o)
);

// File: tb/test_cmd_spi_target.sv
module test_cmd_spi_target;

   localparam int CLK_PERIOD = 10;
   localparam int HALF       = 8;    // system clocks per serial half period
   localparam int GAP        = 12;   // system clocks after chip select rises

   logic        clk = 1'b0, rst_n = 1'b0, csn = 1'b1, sclk = 1'b0, sdi = 1'b0;
   logic [15:0] diag = 16'h0000;
   logic [7:0]  ostate = 8'h00;
   logic        sdo, sdo_oe, diag_clr, regs_rst;
   logic [7:0]  route, combine, ovl, temp, slew, sw;

   always #(CLK_PERIOD/2) clk = ~clk;

   cmd_spi_target i_cmd_spi_target (
      .clk(clk), .rst_n(rst_n), .csn_i(csn), .sclk_i(sclk), .sdi_i(sdi),
      .sdo_o(sdo), .sdo_oe_o(sdo_oe), .diag_i(diag), .out_state_i(ostate),
      .route_o(route), .combine_o(combine), .ovl_latch_o(ovl), .temp_latch_o(temp),
      .slow_slew_o(slew), .switch_o(sw), .diag_clr_o(diag_clr), .regs_rst_o(regs_rst)
   );

   int checks = 0, errors = 0, clr_cnt = 0, rst_cnt = 0;

   always @(negedge clk) begin
      if (rst_n) begin
         clr_cnt += int'(diag_clr);
         rst_cnt += int'(regs_rst);
      end
   end

   logic [7:0] mdl [8];
   bit         rd_pend;
   logic [2:0] rd_addr;

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic mdl_reset();
      for (int i = 0; i < 8; i++) mdl[i] = 8'h00;
      mdl[1] = 8'h08;
   endtask

   task automatic chk_regs(input string req);
      chk(req, "route",   32'(route),   32'(mdl[1]));
      chk(req, "combine", 32'(combine), 32'(mdl[2]));
      chk(req, "ovl",     32'(ovl),     32'(mdl[3]));
      chk(req, "temp",    32'(temp),    32'(mdl[4]));
      chk(req, "slew",    32'(slew),    32'(mdl[5]));
      chk(req, "switch",  32'(sw),      32'(mdl[7]));
   endtask

   function automatic bit legal(input logic [15:0] w);
      case (w[15:14])
         2'b00, 2'b10: return 1'b1;
         2'b01:        return w[10:8] != 3'd0;
         default:      return w[10:8] != 3'd0 && w[10:8] != 3'd6;
      endcase
   endfunction

   task automatic run_frame(input int n, input logic [23:0] v, input string req);
      logic [15:0] load, word;
      logic [23:0] got, expg;
      int          c0, r0;
      bit          lenok, ok;
      load = rd_pend ? {5'b01000, rd_addr, (rd_addr == 3'd6) ? ostate : mdl[rd_addr]} : diag;
      rd_pend = 1'b0;
      got = '0; expg = '0; c0 = clr_cnt; r0 = rst_cnt;
      @(negedge clk) csn = 1'b0;
      repeat (HALF) @(negedge clk);
      for (int k = 0; k < n; k++) begin
         sclk = 1'b1; sdi = v[n-1-k];
         repeat (HALF) @(negedge clk);
         got[n-1-k] = sdo;
         if (k < 16) expg[n-1-k] = load[15-k];
         if (k == 0) chk("R2", "drive enable in frame", 32'(sdo_oe), 32'd1);
         sclk = 1'b0;
         repeat (HALF) @(negedge clk);
      end
      csn = 1'b1;
      repeat (GAP) @(negedge clk);
      chk("R1/R3/R5", "returned bits", 32'(got), 32'(expg));
      word  = (n >= 16) ? v[15:0] : (v[15:0] & 16'((1 << n) - 1));
      lenok = (n > 0) && (n % 8 == 0);
      ok    = lenok && legal(word);
      chk(req, "clear pulses", 32'(clr_cnt - c0), 32'(ok));
      chk(req, "reset pulses", 32'(rst_cnt - r0), 32'(ok && word[15:14] == 2'b10));
      if (ok) begin
         case (word[15:14])
            2'b01:   begin rd_pend = 1'b1; rd_addr = word[10:8]; end
            2'b10:   mdl_reset();
            2'b11:   mdl[word[10:8]] = word[7:0];
            default: ;
         endcase
      end
      chk_regs(req);
      chk("R2", "released after frame", 32'(sdo_oe), 32'd0);
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      int ops [4];
      logic [15:0] w;
      string req;
      ops = '{3, 1, 0, 2};
      mdl_reset();
      rd_pend = 1'b0;
      repeat (5) @(negedge clk);
      // R11: state held in reset
      chk_regs("R11");
      chk("R11", "drive enable in reset", 32'(sdo_oe), 32'd0);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      chk("R11", "no pulses after reset", 32'(clr_cnt + rst_cnt), 32'd0);

      // Sweep every operation against every address; ignored bits set to 101 (R4).
      for (int oi = 0; oi < 4; oi++) begin
         for (int a = 0; a < 8; a++) begin
            diag   = 16'(16'hA5C3 ^ ((oi * 8 + a) * 273));
            ostate = 8'(a * 29 + 7);
            w = {2'(ops[oi]), 3'b101, 3'(a), 8'(a * 37 + oi * 11 + 1)};
            if (!legal(w))           req = "R9";
            else if (ops[oi] == 3)   req = "R4";
            else if (ops[oi] == 1)   req = "R5";
            else if (ops[oi] == 0)   req = "R7";
            else                     req = "R6";
            run_frame(16, {8'h00, w}, req);
            diag = 16'(diag + 16'h1357);
            run_frame(16, 24'h000000, "R10");   // probe frame: returns read data or diagnosis
         end
      end

      // R8: every clock count from 0 to 24 with a write to address 7.
      for (int n = 0; n <= 24; n++) begin
         diag = 16'(16'h3C00 + n);
         run_frame(n, {8'h3C, 2'b11, 3'b000, 3'd7, 8'(n * 9 + 3)}, "R8");
      end

      // R2: serial activity with chip select high has no effect.
      begin
         int c0;
         c0 = clr_cnt + rst_cnt;
         run_frame(16, {8'h00, 16'hC3AB}, "R4");
         for (int k = 0; k < 16; k++) begin
            @(negedge clk) sclk = 1'b1; sdi = ~sdi;
            repeat (4) @(negedge clk);
            if (k == 8) chk("R2", "pad released while idle", 32'(sdo_oe), 32'd0);
            sclk = 1'b0;
            repeat (4) @(negedge clk);
         end
         repeat (GAP) @(negedge clk);
         chk("R2", "no pulse from idle clocks", 32'(clr_cnt + rst_cnt - c0), 32'd1);
         chk_regs("R2");
         diag = 16'h5AA5;
         run_frame(16, 24'h000000, "R2");
      end

      // R11: reset in operation restores defaults and drops a pending read.
      run_frame(16, {8'h00, 16'hC1FF}, "R4");
      run_frame(16, {8'h00, 16'h4100}, "R5");
      @(negedge clk) rst_n = 1'b0;
      repeat (4) @(negedge clk);
      mdl_reset();
      rd_pend = 1'b0;
      chk_regs("R11");
      chk("R11", "drive enable in reset", 32'(sdo_oe), 32'd0);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      diag = 16'h0F0F;
      run_frame(16, 24'h000000, "R11");

      finish_run();
   end

endmodule